// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire SMBus/I2C-style serial bus. A host uses it to read and write a small bank of byte-wide configuration registers, such as per-output enable bits. The register contents are always visible as a flat parallel bus, so neighbouring logic can use them directly. The clock and data lines are brought in as plain inputs, sampled on the system clock through a synchronizer. The block pulls the data line low through a single output-enable pin, and the pad itself implements the open-drain behaviour. Start and stop conditions are found by watching the synchronized data line change while the synchronized clock line is high.

After the address byte, the master sends a command byte. Its top bit selects the access kind. When the top bit is set, the access is a single indexed byte, and the offset comes from the lower seven bits. When the top bit is clear, the access is a sequential block transfer that begins at offset zero. In a block transfer, a byte count travels ahead of the data. A read always starts with a write of the command byte, then a repeated start, then the address with the read bit set. Every pin is a plain level signal. The block has no streaming interface and applies no back-pressure, because the pace of the bus is set entirely by the master's clock line.

Top module: `smb_cfg_regfile`

## Requirements
- R1: The block answers only to address byte 0xD2 (write) and 0xD3 (read). For any other address it pulls SDA low neither on the acknowledge clock nor on any later clock until the next start.
- R2: A command byte with bit 7 = 1, followed by one data byte, writes that data byte to the register at the offset in command bits 6:0.
- R3: A command byte with bit 7 = 1, followed by a repeated start and address 0xD3, returns the register at the offset in command bits 6:0.
- R4: A command byte with bit 7 = 0 starts a block write. The next byte is a byte count. The data bytes after it go to offsets 0, 1, 2 and upward, in order.
- R5: A command byte with bit 7 = 0, followed by a repeated start and address 0xD3, returns the register count (8) first and then registers 0, 1, 2 and upward in order.
- R6: Every byte moves on the wire most significant bit first. Register k appears on cfg_o[8k+7:8k].
- R7: A stop can end a block transfer after any byte. Every byte that was fully received takes effect. A byte cut short by a stop changes nothing.
- R8: On reset, every register loads its value from the DEFAULTS parameter, and SDA is released.
- R9: A write to an offset of 8 or more is acknowledged and then discarded. A read from such an offset returns 0x00.
- R10: The block acknowledges the address, the command and each written byte by pulling SDA low for the ninth clock. When the master NACKs a read byte, the read ends and the block releases SDA.
- R11: A start condition aborts any transfer in progress and begins a new address phase. The block changes SDA and cfg_o only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_o | output | NREG*8 | All registers concatenated, register k at bits 8k+7:8k |

## Verification
The bench goes after offset handling. A byte write is placed at a non-zero offset and read back through a repeated start. An out-of-range offset is written and then read, so a design that wrapped the offset would corrupt a real register and return its contents instead of zero. A block write is stopped four bits into its third data byte. A design that committed a byte before it was complete, or that lost the bytes already accepted, would then show the wrong contents in the first three registers. A byte write with the value 0x01 catches a design that shifts least significant bit first, which would store 0x80. A transfer to a foreign address, a NACK that ends a block read, and a start in the middle of a byte check that the slave never holds the line low when it should not, and that a restarted transfer still works.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA
  } phase_t;
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_q    = scl_sh[SYNC_STAGES-1];
  assign sda_q    = sda_sh[SYNC_STAGES-1];
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int unsigned NREG = 8,
  parameter logic [NREG*8-1:0] DEFAULTS = {NREG{8'hFF}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [6:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] cfg_o
);
  logic [7:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[k] <= DEFAULTS[8*k +: 8];
      else if (we && addr == 7'(k))
        regs[k] <= wdata;
    end
    assign cfg_o[8*k +: 8] = regs[k];
  end

  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (addr == 7'(k)) rdata = regs[k];
  end
endmodule

// File: rtl/smb_protocol.sv
module smb_protocol
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR = 7'h69,
  parameter int unsigned NREG     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_q,
  input  logic [7:0] rd_data,
  output logic       reg_we,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       sda_oe
);
  phase_t     ph;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh, nxt_tx;
  logic       in_ack, ack_rose, cnt_pend;
  logic [6:0] ptr, ptr_inc;

  assign ptr_inc   = (ptr == 7'h7F) ? ptr : ptr + 7'd1;
  assign nxt_tx    = cnt_pend ? 8'(NREG) : rd_data;
  assign reg_addr  = ptr;
  assign reg_wdata = shreg;
  assign reg_we    = !start_ev && !stop_ev && (ph == PH_WDATA) && !in_ack
                     && scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      in_ack   <= 1'b0;
      ack_rose <= 1'b0;
      cnt_pend <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      ph       <= PH_ADDR;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      ack_rose <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_ev) begin
      ph       <= PH_IDLE;
      in_ack   <= 1'b0;
      ack_rose <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (ph != PH_IDLE) begin
      if (in_ack) begin
        // slave-driven acknowledge slot, or master ACK already taken
        if (scl_rise) begin
          ack_rose <= 1'b1;
        end else if (scl_fall && ack_rose) begin
          in_ack   <= 1'b0;
          ack_rose <= 1'b0;
          bitcnt   <= '0;
          if (ph == PH_RDATA) begin
            txsh   <= nxt_tx;
            sda_oe <= ~nxt_tx[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end else if (ph == PH_RDATA) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            if (sda_q) begin
              ph <= PH_IDLE;            // master NACK ends the read
            end else begin
              if (cnt_pend) cnt_pend <= 1'b0;
              else          ptr      <= ptr_inc;
              in_ack   <= 1'b1;
              ack_rose <= 1'b1;
            end
          end else begin
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;             // hand the line to the master
          end else begin
            txsh   <= {txsh[6:0], 1'b0};
            sda_oe <= ~txsh[6];
          end
        end
      end else begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_q};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          in_ack   <= 1'b1;
          ack_rose <= 1'b0;
          sda_oe   <= 1'b1;
          unique case (ph)
            PH_ADDR: begin
              if (shreg[7:1] == SLV_ADDR) begin
                ph <= shreg[0] ? PH_RDATA : PH_CMD;
              end else begin
                ph     <= PH_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
              end
            end
            PH_CMD: begin
              cnt_pend <= ~shreg[7];
              ptr      <= shreg[7] ? shreg[6:0] : 7'd0;
              ph       <= shreg[7] ? PH_WDATA : PH_COUNT;
            end
            PH_COUNT: ph  <= PH_WDATA;
            PH_WDATA: ptr <= ptr_inc;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smb_cfg_regfile.sv
module smb_cfg_regfile #(
  parameter logic [6:0]        SLV_ADDR    = 7'h69,
  parameter int unsigned       NREG        = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] DEFAULTS    = {NREG{8'hFF}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  logic       scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  logic       reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, rd_data;

  smb_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_protocol #(.SLV_ADDR(SLV_ADDR), .NREG(NREG)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_q(sda_q), .rd_data(rd_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sda_oe(sda_oe)
  );

  smb_regbank #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(rd_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk #(
  parameter int unsigned NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_o
);
  logic [NREG*8-1:0] prev_cfg;
  logic              prev_ok;
  logic [NREG-1:0]   byte_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cfg <= '0;
      prev_ok  <= 1'b0;
    end else begin
      prev_cfg <= cfg_o;
      prev_ok  <= 1'b1;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_chg
    assign byte_chg[k] = cfg_o[8*k +: 8] != prev_cfg[8*k +: 8];
  end

  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q);

  // R11
  cfg_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> !scl_q);

  // R4
  one_byte_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> $onehot0(byte_chg));

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind smb_cfg_regfile smb_cfg_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .cfg_o(cfg_o)
);

// File: tb/tb_smb_cfg_regfile.sv
`timescale 1ns/1ps
module tb_smb_cfg_regfile;
  localparam int NREG = 8;
  localparam logic [NREG*8-1:0] DEF = 64'h7E6D_5C4B_3A29_1807;
  localparam int Q = 40;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_o;
  wire sda_line = sda_m & ~sda_oe;
  int n_chk = 0, n_err = 0;
  logic [7:0] mdl [NREG];

  always #2 clk = ~clk;

  smb_cfg_regfile #(.NREG(NREG), .DEFAULTS(DEF)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; acked = !sda_line; #Q; scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #Q; scl = 1'b1; #Q; b = {b[6:0], sda_line}; #Q; scl = 1'b0;
    end
    #Q; sda_m = nack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; sda_m = 1'b1;
  endtask

  function automatic logic [7:0] reg_at(input int k);
    return cfg_o[8*k +: 8];
  endfunction

  task automatic cmp_all(input string req);
    for (int k = 0; k < NREG; k++) check(reg_at(k) == mdl[k], req, reg_at(k), mdl[k]);
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] v, input string req);
    bit a;
    bus_start();
    send_byte(8'hD2, a); check(a, "R10 addr ack", a, 1);
    send_byte({1'b1, off}, a); check(a, "R10 cmd ack", a, 1);
    send_byte(v, a); check(a, {req, " data ack R10"}, a, 1);
    bus_stop();
    if (off < NREG) mdl[off] = v;
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] v);
    bit a;
    bus_start();
    send_byte(8'hD2, a); check(a, "R10 addr ack", a, 1);
    send_byte({1'b1, off}, a); check(a, "R10 cmd ack", a, 1);
    bus_start();
    send_byte(8'hD3, a); check(a, "R3 read addr ack", a, 1);
    recv_byte(1'b1, v);
    bus_stop();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R8 sda released", sda_oe, 0);
    check(cfg_o == DEF, "R8 defaults", cfg_o, DEF);
  endtask

  task automatic t_foreign_addr();
    bit a;
    bus_start();
    send_byte(8'hA0, a); check(!a, "R1 foreign addr nack", a, 0);
    send_byte(8'h81, a); check(!a, "R1 no drive after foreign addr", a, 0);
    send_byte(8'h00, a); check(!a, "R1 no drive on data", a, 0);
    bus_stop();
    cmp_all("R1 regs untouched");
  endtask

  task automatic t_byte_write();
    byte_write(7'd3, 8'h5A, "R2");
    cmp_all("R2 byte write at offset 3");
  endtask

  task automatic t_byte_read();
    logic [7:0] v;
    byte_read(7'd3, v); check(v == 8'h5A, "R3 read offset 3", v, 8'h5A);
    byte_read(7'd7, v); check(v == mdl[7], "R3 read offset 7", v, mdl[7]);
  endtask

  task automatic t_msb_first();
    logic [7:0] v;
    byte_write(7'd5, 8'h01, "R6");
    check(reg_at(5) == 8'h01, "R6 msb first write", reg_at(5), 8'h01);
    byte_write(7'd6, 8'hC0, "R6");
    byte_read(7'd6, v); check(v == 8'hC0, "R6 msb first read", v, 8'hC0);
  endtask

  task automatic t_block_write();
    bit a;
    logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); check(a, "R4 cmd ack", a, 1);
    send_byte(8'h04, a); check(a, "R4 count ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(d[i], a); check(a, "R4 data ack R10", a, 1);
      mdl[i] = d[i];
    end
    bus_stop();
    cmp_all("R4 block write order");
  endtask

  task automatic t_block_read();
    bit a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start();
    send_byte(8'hD3, a); check(a, "R5 read addr ack", a, 1);
    recv_byte(1'b0, v); check(v == 8'(NREG), "R5 count first", v, NREG);
    for (int k = 0; k < NREG; k++) begin
      recv_byte(k == NREG - 1, v);
      check(v == mdl[k], "R5 block read data", v, mdl[k]);
    end
    check(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q;
    check(sda_line == 1'b1, "R10 no drive after nack", sda_line, 1);
    #Q; scl = 1'b0; #Q;
    bus_stop();
  endtask

  task automatic t_partial_block();
    bit a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h08, a);
    send_byte(8'hA1, a); mdl[0] = 8'hA1;
    send_byte(8'hB2, a); mdl[1] = 8'hB2;
    send_bits(8'hFF, 4);
    bus_stop();
    cmp_all("R7 stop mid block");
  endtask

  task automatic t_out_of_range();
    logic [7:0] v;
    byte_write(7'h20, 8'h77, "R9");
    cmp_all("R9 out-of-range write discarded");
    byte_read(7'h20, v); check(v == 8'h00, "R9 out-of-range read", v, 0);
  endtask

  task automatic t_restart();
    bit a;
    bus_start();
    send_byte(8'hD2, a);
    send_bits(8'h86, 4);
    bus_start();
    send_byte(8'hD2, a); check(a, "R11 addr ack after restart", a, 1);
    send_byte(8'h86, a); send_byte(8'hC3, a); check(a, "R11 data ack", a, 1);
    bus_stop();
    mdl[6] = 8'hC3;
    cmp_all("R11 write after mid-byte start");
  endtask

  initial begin
    #(150000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int k = 0; k < NREG; k++) mdl[k] = DEF[8*k +: 8];
    #41; rst_n = 1'b1; #Q;
    t_reset();
    t_foreign_addr();
    t_byte_write();
    t_byte_read();
    t_msb_first();
    t_block_write();
    t_block_read();
    t_partial_block();
    t_out_of_range();
    t_restart();
    #Q;
    report();
  end
endmodule